// File: doc/BRIEF.md
# Per-CPU Timer and Inter-Processor Interrupt Controller

This block holds the interrupt state for up to four processors in one shared 64-bit control word. Each processor has a timer flag and an inter-processor flag there. The word also carries two small arbitration-status nibbles and a four-bit general-purpose field. Every field group follows its own write rule. Software clears flags by writing ones. One processor signals another by writing a one to a request bit. The arbitration nibbles either accumulate, latch only from empty, or are wiped together by a single clear-all bit.

A shared periodic tick drives one 25-bit ignore counter per processor. Each rising edge of the tick decrements the counter of every present processor. Once a counter passes below zero, its top bit stays set, and from then on every tick raises that processor's timer flag. Software therefore decides how many ticks each processor skips by reloading its counter. A present mask gates the counters and both interrupt outputs, so an absent processor never sees an interrupt.

Top module: `cpu_tick_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_0008_0000_0000 (bit 35 is a fixed revision indicator), all four counters read 0, and all interrupt outputs are low.
- R2: Reads are combinational. Address 0 returns the control word with the requester's 2-bit CPU index placed in bits 1:0. Addresses 4+i return counter i in bits 24:0 with zeros above. Every other address returns zero. Writes to bits 1:0 have no effect.
- R3: In the control word, timer flags for CPU i sit at bit 4+i and inter-processor flags for CPU i sit at bit 8+i. Writing a 1 to any of these bits clears it, and writing a 0 leaves it unchanged.
- R4: Writing a 1 to bit 12+i sets the inter-processor flag of CPU i. If the same write also clears that flag, the set wins. Bits 15:12 always read as zero.
- R5: A write with bit 20 set clears bits 23:16. If bit 20 is clear, ones written to bits 23:20 are added to the bits already set there.
- R6: If bit 20 of a write is clear, ones in bits 19:16 are stored only when bits 19:16 were all zero before the write. Otherwise that nibble is left unchanged.
- R7: Bits 43:40 are plain read/write storage. Bit 35 stays 1 and all other bits stay 0 whatever is written.
- R8: A write to counter i stores the low 24 bits of the data and clears overflow bit 24.
- R9: On a rising edge of tick_i, each present CPU's counter becomes (value − 1) mod 2^25, with bit 24 kept set if it was already set. Absent CPUs' counters hold their value. A steady high or low level on tick_i, or a falling edge, has no effect.
- R10: When a tick leaves bit 24 of counter i set, the timer flag of CPU i is set. This holds even when a control write in the same cycle clears that flag.
- R11: ipi_irq_o[i] equals the inter-processor flag of CPU i ANDed with present_i[i]. tmr_irq_o[i] equals the timer flag of CPU i ANDed with present_i[i].
- R12: When a counter write and a tick rising edge reach the same counter in the same cycle, the written value is stored and no decrement takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| present_i | input | NCPU | Mask of processors that exist |
| cpu_id_i | input | 2 | Index of the processor issuing the read |
| reg_addr_i | input | 3 | Register select: 0 control word, 4+i counter i |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Combinational read data |
| tick_i | input | 1 | Shared periodic timer tick, acts on its rising edge |
| ipi_irq_o | output | NCPU | Inter-processor interrupt per processor |
| tmr_irq_o | output | NCPU | Timer interrupt per processor |

## Verification
The hardest state to reach from the ports is a counter that has passed below zero and then keeps decrementing with its sticky top bit. This state must then meet a control write or a counter write in the very cycle of a tick edge. The stimulus loads small counts so that an overflow arrives within three ticks. It holds each tick high for several cycles to show that only the edge counts. It then raises the tick in the same cycle as a write, once against a counter reload and once against a clear of the timer flag. Arbitration-nibble rules are walked as a table of write/read-back pairs in which each entry depends on the state left by the one before.

// File: rtl/cpu_tick_irq_pkg.sv
`timescale 1ns/1ps
package cpu_tick_irq_pkg;

    localparam int DATA_W     = 64;
    localparam int ID_W       = 2;
    localparam int SLOT_W     = 4;
    localparam int REG_ADDR_W = 3;
    localparam int CNT_BASE   = 4;
    localparam logic [REG_ADDR_W-1:0] CTRL_ADDR = '0;

    // bit positions software decodes
    localparam int ITI_LSB   = 4;
    localparam int IPI_LSB   = 8;
    localparam int REQ_LSB   = 12;
    localparam int ABW_LSB   = 16;
    localparam int ABT_LSB   = 20;
    localparam int CLR_BIT   = 20;
    localparam int REV_BIT   = 35;
    localparam int USER_LSB  = 40;

    typedef struct packed {
        logic [SLOT_W-1:0] user;
        logic [SLOT_W-1:0] abt;
        logic [SLOT_W-1:0] abw;
        logic [SLOT_W-1:0] ipi;
        logic [SLOT_W-1:0] iti;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        logic  tick_seen;
    } top_state_t;

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[REV_BIT]                   = 1'b1;
        w[ITI_LSB  +: SLOT_W]        = c.iti;
        w[IPI_LSB  +: SLOT_W]        = c.ipi;
        w[ABW_LSB  +: SLOT_W]        = c.abw;
        w[ABT_LSB  +: SLOT_W]        = c.abt;
        w[USER_LSB +: SLOT_W]        = c.user;
        return w;
    endfunction

endpackage

// File: rtl/cpu_tick_ign_cnt.sv
`timescale 1ns/1ps
module cpu_tick_ign_cnt #(
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             present_i,
    input  logic             tick_rise_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W:0]   cnt_o,
    output logic             ovf_tick_o
);
    logic [CNT_W:0] cnt_d, cnt_q;
    logic [CNT_W:0] dec;

    always_comb begin
        dec        = cnt_q - (CNT_W+1)'(1);
        dec[CNT_W] = dec[CNT_W] | cnt_q[CNT_W];   // overflow is sticky
        cnt_d      = cnt_q;
        ovf_tick_o = 1'b0;
        if (load_i) begin
            cnt_d = {1'b0, load_val_i};           // load wins over a tick
        end else if (tick_rise_i && present_i) begin
            cnt_d      = dec;
            ovf_tick_o = dec[CNT_W];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cpu_tick_ctrl_next.sv
`timescale 1ns/1ps
module cpu_tick_ctrl_next
    import cpu_tick_irq_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  ctrl_t             ctrl_q_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NCPU-1:0]   tick_ovf_i,
    output ctrl_t             ctrl_d_o
);
    localparam logic [SLOT_W-1:0] SLOT_MASK = SLOT_W'((1 << NCPU) - 1);

    logic [SLOT_W-1:0] ovf_wide;
    logic              unused_wdata;

    assign unused_wdata = ^{wdata_i[DATA_W-1:USER_LSB+SLOT_W],
                            wdata_i[USER_LSB-1:ABT_LSB+SLOT_W],
                            wdata_i[ITI_LSB-1:0]};

    always_comb begin
        ovf_wide            = '0;
        ovf_wide[NCPU-1:0]  = tick_ovf_i;
    end

    always_comb begin
        ctrl_d_o = ctrl_q_i;
        if (wr_i) begin
            ctrl_d_o.iti = ctrl_q_i.iti & ~wdata_i[ITI_LSB +: SLOT_W];
            ctrl_d_o.ipi = ctrl_q_i.ipi & ~wdata_i[IPI_LSB +: SLOT_W];
            if (wdata_i[CLR_BIT]) begin
                ctrl_d_o.abt = '0;
                ctrl_d_o.abw = '0;
            end else begin
                ctrl_d_o.abt = ctrl_q_i.abt | wdata_i[ABT_LSB +: SLOT_W];
                if (ctrl_q_i.abw == '0)
                    ctrl_d_o.abw = wdata_i[ABW_LSB +: SLOT_W];
            end
            // request bits set after the clear, so a set wins
            ctrl_d_o.ipi  = (ctrl_d_o.ipi | wdata_i[REQ_LSB +: SLOT_W]) & SLOT_MASK;
            ctrl_d_o.user = wdata_i[USER_LSB +: SLOT_W];
        end
        // tick overflow applied last, so it wins over a same-cycle clear
        ctrl_d_o.iti = (ctrl_d_o.iti | ovf_wide) & SLOT_MASK;
    end
endmodule

// File: rtl/cpu_tick_rd_mux.sv
`timescale 1ns/1ps
module cpu_tick_rd_mux
    import cpu_tick_irq_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CNT_W = 24
) (
    input  logic [REG_ADDR_W-1:0]   addr_i,
    input  logic [ID_W-1:0]         cpu_id_i,
    input  logic [DATA_W-1:0]       ctrl_word_i,
    input  logic [NCPU-1:0][CNT_W:0] cnt_i,
    output logic [DATA_W-1:0]       rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_ADDR) begin
            rdata_o            = ctrl_word_i;
            rdata_o[ID_W-1:0]  = cpu_id_i;
        end
        for (int k = 0; k < NCPU; k++) begin
            if (addr_i == REG_ADDR_W'(CNT_BASE + k))
                rdata_o = {{(DATA_W-CNT_W-1){1'b0}}, cnt_i[k]};
        end
    end
endmodule

// File: rtl/cpu_tick_irq_ctrl.sv
`timescale 1ns/1ps
module cpu_tick_irq_ctrl
    import cpu_tick_irq_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CNT_W = 24
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NCPU-1:0]       present_i,
    input  logic [ID_W-1:0]       cpu_id_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic                  wr_en_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    output logic [DATA_W-1:0]     rd_data_o,
    input  logic                  tick_i,
    output logic [NCPU-1:0]       ipi_irq_o,
    output logic [NCPU-1:0]       tmr_irq_o
);
    top_state_t              st_d, st_q;
    ctrl_t                   ctrl_nx;
    logic                    tick_rise;
    logic                    ctrl_wr;
    logic [NCPU-1:0]         cnt_wr;
    logic [NCPU-1:0]         tick_ovf;
    logic [NCPU-1:0][CNT_W:0] cnt_all;
    logic [DATA_W-1:0]       ctrl_word;

    assign tick_rise = tick_i & ~st_q.tick_seen;
    assign ctrl_wr   = wr_en_i && (reg_addr_i == CTRL_ADDR);

    for (genvar g = 0; g < NCPU; g++) begin : g_cnt
        assign cnt_wr[g] = wr_en_i && (reg_addr_i == REG_ADDR_W'(CNT_BASE + g));
        cpu_tick_ign_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .present_i  (present_i[g]),
            .tick_rise_i(tick_rise),
            .load_i     (cnt_wr[g]),
            .load_val_i (wr_data_i[CNT_W-1:0]),
            .cnt_o      (cnt_all[g]),
            .ovf_tick_o (tick_ovf[g])
        );
    end

    cpu_tick_ctrl_next #(.NCPU(NCPU)) u_next (
        .ctrl_q_i  (st_q.ctrl),
        .wr_i      (ctrl_wr),
        .wdata_i   (wr_data_i),
        .tick_ovf_i(tick_ovf),
        .ctrl_d_o  (ctrl_nx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.ctrl      = ctrl_nx;
        st_d.tick_seen = tick_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctrl_word = ctrl_to_word(st_q.ctrl);

    cpu_tick_rd_mux #(.NCPU(NCPU), .CNT_W(CNT_W)) u_rd (
        .addr_i     (reg_addr_i),
        .cpu_id_i   (cpu_id_i),
        .ctrl_word_i(ctrl_word),
        .cnt_i      (cnt_all),
        .rdata_o    (rd_data_o)
    );

    assign ipi_irq_o = st_q.ctrl.ipi[NCPU-1:0] & present_i;
    assign tmr_irq_o = st_q.ctrl.iti[NCPU-1:0] & present_i;
endmodule

// File: rtl/cpu_tick_irq_chk.sv
`timescale 1ns/1ps
module cpu_tick_irq_chk
    import cpu_tick_irq_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CNT_W = 24
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   wr_en_i,
    input logic [REG_ADDR_W-1:0]  reg_addr_i,
    input logic [CNT_W-1:0]       wdata_cnt,
    input logic                   wdata_clr,
    input logic [NCPU-1:0]        wdata_req,
    input logic                   tick_i,
    input logic [NCPU-1:0]        present_i,
    input logic [NCPU-1:0]        ipi_irq_o,
    input logic [NCPU-1:0]        iti_bits,
    input logic [2*SLOT_W-1:0]    arb_bits,
    input logic [NCPU-1:0][CNT_W:0] cnt_all
);
    AST_ALL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && reg_addr_i == CTRL_ADDR && wdata_clr) |=> (arb_bits == '0)); // R5

    AST_IPI_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && reg_addr_i == CTRL_ADDR)
        |=> (((ipi_irq_o | ~present_i) & $past(wdata_req)) == $past(wdata_req))); // R4

    AST_NO_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !wr_en_i) |=> $stable(cnt_all)); // R9

    for (genvar i = 0; i < NCPU; i++) begin : g_chk
        AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && reg_addr_i == REG_ADDR_W'(CNT_BASE + i))
            |=> (cnt_all[i] == {1'b0, $past(wdata_cnt)})); // R8

        AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cnt_all[i][CNT_W] && !(wr_en_i && reg_addr_i == REG_ADDR_W'(CNT_BASE + i)))
            |=> cnt_all[i][CNT_W]); // R9

        AST_ITI_FROM_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(iti_bits[i]) |-> cnt_all[i][CNT_W]); // R10
    end
endmodule

bind cpu_tick_irq_ctrl cpu_tick_irq_chk #(.NCPU(NCPU), .CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .reg_addr_i(reg_addr_i),
    .wdata_cnt (wr_data_i[CNT_W-1:0]),
    .wdata_clr (wr_data_i[cpu_tick_irq_pkg::CLR_BIT]),
    .wdata_req (wr_data_i[cpu_tick_irq_pkg::REQ_LSB +: NCPU]),
    .tick_i    (tick_i),
    .present_i (present_i),
    .ipi_irq_o (ipi_irq_o),
    .iti_bits  (ctrl_word[cpu_tick_irq_pkg::ITI_LSB +: NCPU]),
    .arb_bits  (ctrl_word[cpu_tick_irq_pkg::ABT_LSB+cpu_tick_irq_pkg::SLOT_W-1:cpu_tick_irq_pkg::ABW_LSB]),
    .cnt_all   (cnt_all)
);

// File: tb/test_cpu_tick_irq_ctrl.sv
`timescale 1ns/1ps
module test_cpu_tick_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  present = 4'b1111;
    logic [1:0]  cpu_id = '0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        tick = 1'b0;
    logic [3:0]  ipi, tmr;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    cpu_tick_irq_ctrl i_cpu_tick_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .present_i(present), .cpu_id_i(cpu_id),
        .reg_addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata), .rd_data_o(rdata),
        .tick_i(tick), .ipi_irq_o(ipi), .tmr_irq_o(tmr)
    );

    typedef struct packed {
        logic [63:0] wd;
        logic [1:0]  rid;
        logic [63:0] exp;
        logic [3:0]  tag;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_0000_0000_3000, 2'd2, 64'h0000_0008_0000_0302, 4'd4},  // R4 request two
        '{64'h0000_0000_0000_0100, 2'd1, 64'h0000_0008_0000_0201, 4'd3},  // R3 clear one
        '{64'h0000_0000_0000_1300, 2'd0, 64'h0000_0008_0000_0100, 4'd4},  // R4 set beats clear
        '{64'h0000_0000_0005_0000, 2'd3, 64'h0000_0008_0005_0103, 4'd6},  // R6 from empty
        '{64'h0000_0000_000A_0000, 2'd0, 64'h0000_0008_0005_0100, 4'd6},  // R6 not empty
        '{64'h0000_0000_00C0_0000, 2'd0, 64'h0000_0008_00C5_0100, 4'd5},  // R5 accumulate
        '{64'h0000_0000_0010_0000, 2'd0, 64'h0000_0008_0000_0100, 4'd5},  // R5 clear all
        '{64'h0000_0000_0003_0000, 2'd0, 64'h0000_0008_0003_0100, 4'd6},  // R6 empty again
        '{64'h0000_0A00_0000_0000, 2'd0, 64'h0000_0A08_0003_0100, 4'd7},  // R7 user field
        '{64'h0000_0508_0000_0000, 2'd0, 64'h0000_0508_0003_0100, 4'd7},  // R7 overwrite
        '{64'h0000_0000_0000_0003, 2'd0, 64'h0000_0008_0003_0100, 4'd7},  // R7 R2 ro bits
        '{64'h0000_0000_0011_0000, 2'd0, 64'h0000_0008_0000_0100, 4'd5},  // R5 clear wins
        '{64'h0000_0000_0000_0100, 2'd0, 64'h0000_0008_0000_0000, 4'd3}   // R3 cleanup
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, input logic [1:0] id, output logic [63:0] v);
        addr = a; cpu_id = id;
        #1;
        v = rdata;
    endtask

    // one rising edge, level held for several cycles
    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic tick_with_write(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_reg(3'd0, 2'd0, v); check("R1 ctrl", v, 64'h0000_0008_0000_0000);
        for (int k = 0; k < 4; k++) begin
            read_reg(3'(4 + k), 2'd0, v); check("R1 counter", v, 64'h0);
        end
        check("R1 outputs", {56'h0, ipi, tmr}, 64'h0);

        // R2 read path
        read_reg(3'd0, 2'd3, v); check("R2 id", v, 64'h0000_0008_0000_0003);
        read_reg(3'd1, 2'd0, v); check("R2 unmapped", v, 64'h0);
        read_reg(3'd3, 2'd2, v); check("R2 unmapped", v, 64'h0);

        // table of control-word writes
        for (int k = 0; k < NVEC; k++) begin
            write_reg(3'd0, VECS[k].wd);
            read_reg(3'd0, VECS[k].rid, v);
            check($sformatf("R%0d vec%0d", VECS[k].tag, k), v, VECS[k].exp);
        end
        check("R11 ipi idle", {60'h0, ipi}, 64'h0);

        // R8 load keeps 24 bits
        write_reg(3'd4, 64'hFFFF_FFFF_FF12_3456);
        read_reg(3'd4, 2'd0, v); check("R8 load", v, 64'h12_3456);

        write_reg(3'd4, 64'd2);
        write_reg(3'd5, 64'd0);
        write_reg(3'd6, 64'd5);
        write_reg(3'd7, 64'd100);
        present = 4'b1011;

        pulse_tick();
        check("R10 R11 tmr after tick1", {60'h0, tmr}, 64'h2);
        read_reg(3'd5, 2'd0, v); check("R9 underflow", v, 64'h1FF_FFFF);
        read_reg(3'd4, 2'd0, v); check("R9 level once", v, 64'h1);
        read_reg(3'd6, 2'd0, v); check("R9 absent holds", v, 64'h5);

        pulse_tick();
        pulse_tick();
        check("R10 tmr after tick3", {60'h0, tmr}, 64'h3);
        read_reg(3'd4, 2'd0, v); check("R9 cpu0", v, 64'h1FF_FFFF);
        read_reg(3'd5, 2'd0, v); check("R9 sticky", v, 64'h1FF_FFFD);
        read_reg(3'd7, 2'd0, v); check("R9 cpu3", v, 64'd97);
        read_reg(3'd0, 2'd0, v); check("R10 flags", v, 64'h0000_0008_0000_0030);

        write_reg(3'd0, 64'h20);
        check("R3 R11 clear timer", {60'h0, tmr}, 64'h1);
        pulse_tick();
        check("R10 sticky re-raise", {60'h0, tmr}, 64'h3);

        write_reg(3'd0, 64'h30);
        check("R3 clear both", {60'h0, tmr}, 64'h0);
        write_reg(3'd5, 64'd7);
        read_reg(3'd5, 2'd0, v); check("R8 clears overflow", v, 64'd7);

        // absent CPU gets no IPI
        write_reg(3'd0, 64'h4000);
        read_reg(3'd0, 2'd0, v); check("R4 stored", v, 64'h0000_0008_0000_0400);
        check("R11 absent ipi", {60'h0, ipi}, 64'h0);
        @(negedge clk);
        present = 4'b1111;
        #1;
        check("R11 present ipi", {60'h0, ipi}, 64'h4);
        write_reg(3'd0, 64'h400);
        check("R3 ipi cleared", {60'h0, ipi}, 64'h0);

        // R12 load beats tick
        tick_with_write(3'd4, 64'd9);
        read_reg(3'd4, 2'd0, v); check("R12 load wins", v, 64'd9);
        read_reg(3'd6, 2'd0, v); check("R9 now present", v, 64'd4);

        // R10 tick beats clear
        write_reg(3'd4, 64'd0);
        tick_with_write(3'd0, 64'h10);
        check("R10 tick beats clear", {60'h0, tmr}, 64'h1);
        @(negedge clk);
        present = 4'b1110;
        #1;
        check("R11 absent tmr", {60'h0, tmr}, 64'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule